// File: doc/BRIEF.md
# Predicated Copy with Masked Maximum

This unit streams element triples through a single pass. Each triple holds an integer predicate, a data value and the value the destination held before. A lane whose predicate is nonzero sends the data value out untouched; a lane whose predicate is zero sends the prior destination value out, so the destination is merged rather than overwritten with a constant. At the same time, only the predicate-true data values are folded into a running maximum held in an accumulator register. The accumulator can be read at any time on its own port.

Work is issued as commands. A command gives the number of elements, a signedness mode for the 16-bit data, and a three-way accumulator code. Code 3 restarts the maximum from the identity. Code 0 also starts from the identity and is meant for a single command on its own. Code 2 keeps the current value, so that one maximum can span several commands. Any other code is refused. The element streams use valid/ready handshakes and add no latency: an element is taken in the same cycle the output is accepted.

Top module: `pcmax_unit`

## Requirements
- R1: A lane counts as true when any bit of its predicate is set. The predicate value 0x8000 is true, and only the all-zero predicate is false.
- R2: For a true lane, out_data equals in_data bit for bit.
- R3: For a false lane, out_data equals in_prior, and the accumulator keeps its value when that element is taken.
- R4: With cmd_uns=0, each true lane taken replaces the accumulator when its data is greater as a two's-complement number, so the accumulator holds the signed maximum.
- R5: With cmd_uns=1, the comparison is unsigned. For example, 0xFFFB beats 0x0005.
- R6: Code 3 loads the max identity when the command is accepted: 0x8000 in signed mode and 0x0000 in unsigned mode. The command's true lanes are then folded in.
- R7: Code 2 keeps the accumulator as it is at acceptance, and the command's true lanes are folded into it.
- R8: Code 0 starts from the identity in the same way as code 3. A command with no true lanes leaves exactly the identity.
- R9: Codes 1, 4, 5, 6 and 7 are accepted and refused. err is high for the one following cycle, no element is taken in that cycle (in_ready low), and the accumulator is unchanged.
- R10: While a command runs, out_valid follows in_valid and in_ready follows out_ready. A command takes exactly cmd_len+1 elements, and no element is taken while no command is running.
- R11: cmd_ready is high whenever no command is running. done is high for exactly the one cycle after the last element is taken, with the final maximum on acc_value. acc_value then holds until another command is accepted, and a new command may be accepted in the done cycle.
- R12: During and right after reset, cmd_ready=1, in_ready=0, out_valid=0, done=0, err=0 and acc_value=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit is idle and takes a command |
| cmd_code | input | 3 | Accumulator code: 0 single-shot, 2 chain, 3 restart, others illegal |
| cmd_uns | input | 1 | 1 selects unsigned data, 0 selects signed data |
| cmd_len | input | LEN_W | Number of elements minus one |
| in_valid | input | 1 | Element triple offered |
| in_ready | output | 1 | Element triple taken this cycle when in_valid is high |
| in_pred | input | PRED_W | Integer predicate |
| in_data | input | DATA_W | Data value |
| in_prior | input | DATA_W | Prior destination value |
| out_valid | output | 1 | Destination value offered |
| out_ready | input | 1 | Downstream accepts the destination value |
| out_data | output | DATA_W | Merged destination value |
| acc_value | output | DATA_W | Running maximum |
| done | output | 1 | One-cycle pulse after the last element of a command |
| err | output | 1 | One-cycle pulse after a refused command |

## Verification
Two events can fall in the same cycle. The first is the done pulse that presents a command's final maximum. The second is the acceptance of the next command, which reseeds the accumulator. The bench issues every command in the cycle of the previous done pulse. In that cycle it checks that acc_value still shows the finished result and that cmd_ready is high. One cycle later it checks the reseeded or chained value through the first element's fold. Random commands mix chaining, restarts, signedness changes, gaps on the input and stalls on the output, and a bench model of the maximum judges every element.

// File: rtl/pcmax_pkg.sv
package pcmax_pkg;

  localparam logic [2:0] ACC_SINGLE  = 3'd0;
  localparam logic [2:0] ACC_CHAIN   = 3'd2;
  localparam logic [2:0] ACC_RESTART = 3'd3;

  typedef enum logic {PH_WAIT, PH_RUN} phase_e;

  function automatic logic cmd_legal(input logic [2:0] code);
    return (code == ACC_SINGLE) || (code == ACC_CHAIN) || (code == ACC_RESTART);
  endfunction

  function automatic logic cmd_seeds(input logic [2:0] code);
    return (code == ACC_SINGLE) || (code == ACC_RESTART);
  endfunction

endpackage

// File: rtl/pcmax_ctrl.sv
module pcmax_ctrl
  import pcmax_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_uns,
  input  logic             take,
  output logic             cmd_ready,
  output logic             running,
  output logic             seed_ev,
  output logic             reject_ev,
  output logic             last_ev,
  output logic             mode_uns,
  output logic             done,
  output logic             err
);

  phase_e           phase_q;
  logic [LEN_W-1:0] remain_q;
  logic             cmd_fire;
  logic             start_ev;

  assign cmd_ready = (phase_q == PH_WAIT);
  assign running   = (phase_q == PH_RUN);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign start_ev  = cmd_fire && cmd_legal(cmd_code);
  assign reject_ev = cmd_fire && !cmd_legal(cmd_code);
  assign seed_ev   = start_ev && cmd_seeds(cmd_code);
  assign last_ev   = take && (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_WAIT;
      remain_q <= '0;
      mode_uns <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= last_ev;
      err  <= reject_ev;
      if (start_ev) begin
        phase_q  <= PH_RUN;
        remain_q <= cmd_len;
        mode_uns <= cmd_uns;
      end else if (take) begin
        if (remain_q == '0) phase_q <= PH_WAIT;
        else remain_q <= remain_q - LEN_W'(1);
      end
    end
  end

  // R9
  reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (err && cmd_ready));

  // R11
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> (done && cmd_ready));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pcmax_acc.sv
module pcmax_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              seed_uns,
  input  logic              fold_ev,
  input  logic              fold_uns,
  input  logic [DATA_W-1:0] fold_data,
  output logic [DATA_W-1:0] acc_q
);

  function automatic logic [DATA_W-1:0] max_ident(input logic uns);
    return uns ? '0 : {1'b1, {(DATA_W-1){1'b0}}};
  endfunction

  function automatic logic above(input logic [DATA_W-1:0] a,
                                 input logic [DATA_W-1:0] b,
                                 input logic uns);
    return uns ? (a > b) : ($signed(a) > $signed(b));
  endfunction

  logic wins;
  assign wins = fold_ev && above(fold_data, acc_q, fold_uns);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (seed)  acc_q <= max_ident(seed_uns);
    else if (wins)  acc_q <= fold_data;
  end

  // R4
  fold_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_ev && !seed) |=> !above($past(fold_data), acc_q, $past(fold_uns)));

  // R4
  fold_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_ev && !seed) |=> !above($past(acc_q), acc_q, $past(fold_uns)));

endmodule

// File: rtl/pcmax_unit.sv
module pcmax_unit #(
  parameter int DATA_W = 16,
  parameter int PRED_W = 16,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_code,
  input  logic              cmd_uns,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PRED_W-1:0] in_pred,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] in_prior,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] acc_value,
  output logic              done,
  output logic              err
);

  function automatic logic [DATA_W-1:0] lane_merge(input logic hit,
                                                   input logic [DATA_W-1:0] data,
                                                   input logic [DATA_W-1:0] prior);
    return hit ? data : prior;
  endfunction

  logic running;
  logic seed_ev;
  logic reject_ev;
  logic last_ev;
  logic mode_uns;
  logic take;
  logic pred_true;
  logic fold_ev;

  assign pred_true = |in_pred;
  assign out_valid = in_valid && running;
  assign in_ready  = out_ready && running;
  assign take      = in_valid && in_ready;
  assign fold_ev   = take && pred_true;
  assign out_data  = lane_merge(pred_true, in_data, in_prior);

  pcmax_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_len   (cmd_len),
    .cmd_uns   (cmd_uns),
    .take      (take),
    .cmd_ready (cmd_ready),
    .running   (running),
    .seed_ev   (seed_ev),
    .reject_ev (reject_ev),
    .last_ev   (last_ev),
    .mode_uns  (mode_uns),
    .done      (done),
    .err       (err)
  );

  pcmax_acc #(.DATA_W(DATA_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (seed_ev),
    .seed_uns  (cmd_uns),
    .fold_ev   (fold_ev),
    .fold_uns  (mode_uns),
    .fold_data (in_data),
    .acc_q     (acc_value)
  );

  // R3
  false_lane_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pred_true) |=> $stable(acc_value));

  // R10
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  // R11
  done_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_valid) |=> $stable(acc_value));

  // R9
  err_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);

endmodule

// File: tb/sim_pcmax_unit.sv
module sim_pcmax_unit;
  localparam int DW = 16;
  localparam int PW = 16;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_code = '0;
  logic          cmd_uns = 1'b0;
  logic [LW-1:0] cmd_len = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_pred = '0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] in_prior = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [DW-1:0] acc_value;
  logic          done;
  logic          err;

  always #5 clk = ~clk;

  pcmax_unit #(.DATA_W(DW), .PRED_W(PW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_uns(cmd_uns), .cmd_len(cmd_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_pred(in_pred),
    .in_data(in_data), .in_prior(in_prior), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .acc_value(acc_value),
    .done(done), .err(err)
  );

  int errs = 0;
  int checks = 0;
  logic [DW-1:0] exp_acc = '0;
  bit cur_uns = 1'b0;
  logic [PW-1:0] pv [64];
  logic [DW-1:0] dv [64];
  logic [DW-1:0] qv [64];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] ident(input bit uns);
    return uns ? 16'h0000 : 16'h8000;
  endfunction

  function automatic bit bigger(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit uns);
    if (uns) return a > b;
    return $signed(a) > $signed(b);
  endfunction

  // entered and left just after a falling edge
  task automatic send_cmd(input logic [2:0] code, input bit uns, input int n);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_uns   = uns;
    cmd_len   = LW'(n - 1);
    #1 check("R11 cmd_ready while idle", 32'(cmd_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (code == 3'd0 || code == 3'd2 || code == 3'd3) cur_uns = uns;
    if (code == 3'd0 || code == 3'd3) exp_acc = ident(uns);
  endtask

  task automatic run_elems(input int n, input int ready_pct, input int gap_pct, input string tag);
    for (int i = 0; i < n; i++) begin
      bit took;
      if (int'($urandom % 100) < gap_pct) begin
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1 check("R10 out_valid low in a gap", 32'(out_valid), 32'd0);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pred  = pv[i];
      in_data  = dv[i];
      in_prior = qv[i];
      took = 1'b0;
      while (!took) begin
        out_ready = (int'($urandom % 100) < ready_pct);
        #1;
        check("R10 out_valid follows in_valid", 32'(out_valid), 32'd1);
        if (pv[i] != '0) check("R2 true lane copies data", 32'(out_data), 32'(dv[i]));
        else             check("R3 false lane keeps prior", 32'(out_data), 32'(qv[i]));
        check("R10 in_ready follows out_ready", 32'(in_ready), 32'(out_ready));
        took = out_ready;
        @(posedge clk);
        if (took && pv[i] != '0 && bigger(dv[i], exp_acc, cur_uns)) exp_acc = dv[i];
        @(negedge clk);
        if (took && i != n - 1) begin
          #1;
          if (pv[i] != '0) check("R4 running maximum", 32'(acc_value), 32'(exp_acc));
          else             check("R3 false lane leaves acc", 32'(acc_value), 32'(exp_acc));
          check("R10 no done before last element", 32'(done), 32'd0);
        end
      end
    end
    in_valid = 1'b0;
    #1;
    check("R11 done after last element", 32'(done), 32'd1);
    check({tag, " result on acc_value"}, 32'(acc_value), 32'(exp_acc));
  endtask

  task automatic fill_rand(input int n, input int zero_pct);
    for (int i = 0; i < n; i++) begin
      pv[i] = (int'($urandom % 100) < zero_pct) ? '0 : PW'($urandom);
      if (pv[i] == '0 && int'($urandom % 4) == 0) pv[i] = '0;
      dv[i] = DW'($urandom);
      qv[i] = DW'($urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R12 reset cmd_ready", 32'(cmd_ready), 32'd1);
    check("R12 reset in_ready", 32'(in_ready), 32'd0);
    check("R12 reset out_valid", 32'(out_valid), 32'd0);
    check("R12 reset done", 32'(done), 32'd0);
    check("R12 reset err", 32'(err), 32'd0);
    check("R12 reset acc", 32'(acc_value), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R12 idle after reset in_ready", 32'(in_ready), 32'd0);
    @(negedge clk);

    // R1 R4: 0x8000 predicate is true, signed max -5
    pv[0] = 16'h8000; dv[0] = 16'hFFFB; qv[0] = 16'h1111;
    pv[1] = 16'h0000; dv[1] = 16'h0064; qv[1] = 16'h2222;
    pv[2] = 16'h0001; dv[2] = 16'hFFF9; qv[2] = 16'h3333;
    send_cmd(3'd3, 1'b0, 3);
    run_elems(3, 100, 0, "R1");
    check("R1 sign-bit predicate counted", 32'(acc_value), 32'h0000FFFB);

    // R5: unsigned comparison
    pv[0] = 16'h0001; dv[0] = 16'hFFFB; qv[0] = 16'h0;
    pv[1] = 16'h0002; dv[1] = 16'h0005; qv[1] = 16'h0;
    send_cmd(3'd3, 1'b1, 2);
    run_elems(2, 100, 0, "R5");
    check("R5 unsigned max", 32'(acc_value), 32'h0000FFFB);
    send_cmd(3'd3, 1'b0, 2);
    run_elems(2, 100, 0, "R4");
    check("R4 signed max of same data", 32'(acc_value), 32'h00000005);

    // R8 R6: no true lanes leaves the identity
    for (int i = 0; i < 4; i++) begin pv[i] = '0; dv[i] = 16'h7FFF; qv[i] = DW'(i); end
    send_cmd(3'd0, 1'b0, 4);
    run_elems(4, 100, 0, "R8");
    check("R8 signed identity", 32'(acc_value), 32'h00008000);
    send_cmd(3'd3, 1'b1, 4);
    run_elems(4, 100, 0, "R6");
    check("R6 unsigned identity", 32'(acc_value), 32'h00000000);

    // R7: chaining
    pv[0] = 16'h1; dv[0] = 16'd10; pv[1] = 16'h1; dv[1] = 16'd3;
    send_cmd(3'd3, 1'b0, 2);
    run_elems(2, 100, 0, "R6");
    pv[0] = 16'h4; dv[0] = 16'd9; pv[1] = 16'h4; dv[1] = 16'hFFFF;
    send_cmd(3'd2, 1'b0, 2);
    run_elems(2, 100, 0, "R7");
    check("R7 chained max kept", 32'(acc_value), 32'd10);
    pv[0] = 16'h1; dv[0] = 16'd12;
    send_cmd(3'd2, 1'b0, 1);
    run_elems(1, 100, 0, "R7");
    check("R7 chained max raised", 32'(acc_value), 32'd12);
    pv[0] = 16'h1; dv[0] = 16'd3;
    send_cmd(3'd0, 1'b0, 1);
    run_elems(1, 100, 0, "R8");
    check("R8 single-shot restarts", 32'(acc_value), 32'd3);

    // R9: refused codes
    foreach (pv[k]) if (k < 1) pv[k] = pv[k];
    for (int c = 0; c < 3; c++) begin
      logic [2:0] bad;
      bad = (c == 0) ? 3'd1 : (c == 1) ? 3'd4 : 3'd7;
      send_cmd(bad, 1'b1, 5);
      in_valid = 1'b1; in_pred = 16'h1; in_data = 16'h7FFF; out_ready = 1'b1;
      #1;
      check("R9 err pulse", 32'(err), 32'd1);
      check("R9 no element taken", 32'(in_ready), 32'd0);
      check("R9 acc unchanged", 32'(acc_value), 32'd3);
      @(negedge clk);
      #1;
      check("R9 err one cycle", 32'(err), 32'd0);
      check("R9 still idle", 32'(cmd_ready), 32'd1);
      in_valid = 1'b0;
      @(negedge clk);
    end

    // R11: readout holds while idle
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R11 acc holds while idle", 32'(acc_value), 32'd3);
      check("R11 done low while idle", 32'(done), 32'd0);
      @(negedge clk);
    end

    // random commands, each issued in the previous done cycle
    for (int k = 0; k < 40; k++) begin
      int n;
      logic [2:0] code;
      bit uns;
      n = 1 + int'($urandom % 24);
      case ($urandom % 3)
        0: code = 3'd0;
        1: code = 3'd2;
        default: code = 3'd3;
      endcase
      uns = bit'($urandom % 2);
      fill_rand(n, 40);
      send_cmd(code, uns, n);
      run_elems(n, 70, 20, (code == 3'd2) ? "R7" : "R6");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule